// File: doc/BRIEF.md
# Hashed Page Table Walker

After a translation miss, this block turns a virtual address into a real address by searching a hashed page table held in main storage. It computes a group index from the request address and confines that index to the table size. It reads the selected 128-byte group, which holds eight 16-byte entries, over a simple read port. It then compares one entry per cycle. If no entry in the first group matches, it reads the group at the complemented index and searches that one the same way. The result is either a real address with the slot that produced it, or a page fault.

A request is a 65-bit virtual address, a 42-bit table base and a 19-bit size mask. The base page size is 4 KB.

The read port returns a whole group in one beat. Only one read is outstanding at a time. The block accepts a request only while it is idle, and it reports completion with a one-cycle pulse.

Top module: `hpt_walker`

## Requirements
- R1: The first group index is the XOR of virtual address bits [46:28] with bits [27:12] zero-extended to 19 bits. It is ANDed with the size mask, and the low 11 mask bits are always treated as ones, which sets a minimum table of 256 KB. The read address is the table base ORed with the index shifted left by 7.
- R2: The second group index is the one's complement of the unmasked first hash, masked in the same way. That group is read only after every entry of the first group has failed to match.
- R3: Within a group, entries are compared in slot order 0, 2, 4, 6, 1, 3, 5, 7, and the first match wins. Slot k is read-data bits [128k+127:128k].
- R4: A match in the first group is reported even when a matching entry also exists in the second group.
- R5: Within an entry, bit 0 is valid, bit 1 is the group-select flag, bits [43:2] hold the abbreviated page number and bits [73:44] hold the real page number. Bits [127:74] must be zero. An entry matches only if it is valid, its flag equals the current group (0 for the first, 1 for the second), its abbreviated page number equals virtual address bits [64:23], and its upper bits are zero.
- R6: On a match, `done` pulses for one cycle. At that point `realAddr` is the real page number concatenated with virtual address bits [11:0], `hitSlot` is the slot, and `hitSecondary` shows which group matched.
- R7: If neither group matches, `fault` pulses for one cycle instead of `done`, after exactly two reads.
- R8: `busy` rises in the cycle after a request is accepted. It stays high until the cycle in which `done` or `fault` is high, and in that cycle `busy` is low. `done` and `fault` never rise together.
- R9: A request presented while `busy` is high is ignored. The walk in progress completes with its own result and its own read addresses.
- R10: After reset, `busy`, `done`, `fault` and `memReq` are low.
- R11: `memReq` is a single-cycle pulse per group read. No further read is issued before the data of the previous one has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqVaddr | input | 65 | Virtual address to translate |
| tableBase | input | 42 | Real base address of the page table |
| tableMask | input | 19 | Table size mask for the group index |
| busy | output | 1 | Walk in progress |
| memReq | output | 1 | Group read request pulse |
| memAddr | output | 42 | Real address of the group to read |
| memRdValid | input | 1 | Group read data valid |
| memRdData | input | 1024 | Eight 128-bit entries, slot 0 in the low bits |
| done | output | 1 | Translation found pulse |
| fault | output | 1 | Page fault pulse |
| realAddr | output | 42 | Translated real address |
| hitSlot | output | 3 | Slot of the matching entry |
| hitSecondary | output | 1 | Match came from the second group |

## Verification
The bench places matches so that only a correct search order finds the expected slot:
- Two matching entries in odd and even slots catch a walker that scans slots in plain numeric order, because it would report the odd slot.
- A first-group match in slot 7 set against a second-group match in slot 0 catches a walker that reads the second group too early.
- Entries that differ from a match only by the valid bit, the group flag or one page-number bit must be skipped, otherwise a false translation would be reported.

The read addresses are checked with a zero size mask and with a wide mask, which exposes a missing minimum mask or a missing complement. A second request made during a walk must leave both the result and the read sequence of the first walk unchanged.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_SCAN
  } walkState_e;

  typedef struct packed {
    logic load;
    logic capture;
    logic advance;
    logic flipPass;
    logic hit;
    logic miss;
  } walkStrobe_t;
endpackage

// File: rtl/hpt_ctrl.sv
module hpt_ctrl
  import hpt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRdValid,
  input  logic        entryMatch,
  input  logic        lastStep,
  input  logic        secPass,
  output walkStrobe_t strb,
  output logic        memReq,
  output logic        busy
);
  walkState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strb.load = 1'b1;
        stateNxt  = ST_FETCH;
      end
      ST_FETCH: stateNxt = ST_WAIT;
      ST_WAIT: if (memRdValid) begin
        strb.capture = 1'b1;
        stateNxt     = ST_SCAN;
      end
      ST_SCAN: begin
        if (entryMatch) begin
          strb.hit = 1'b1;
          stateNxt = ST_IDLE;
        end else if (lastStep) begin
          if (!secPass) begin
            strb.flipPass = 1'b1;
            stateNxt      = ST_FETCH;
          end else begin
            strb.miss = 1'b1;
            stateNxt  = ST_IDLE;
          end
        end else begin
          strb.advance = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign memReq = (state == ST_FETCH);
  assign busy   = (state != ST_IDLE);

  // R11: a read request never lasts two cycles
  a_r11_single_fetch: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R11: no new read while waiting for data
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdValid) |=> !memReq);
endmodule

// File: rtl/hpt_dpath.sv
module hpt_dpath
  import hpt_pkg::*;
#(
  parameter int VA_W     = 65,
  parameter int RA_W     = 42,
  parameter int PG_W     = 12,
  parameter int SEG_W    = 28,
  parameter int HASH_W   = 19,
  parameter int MINIDX_W = 11,
  parameter int ENT_W    = 128,
  parameter int ENTS     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  walkStrobe_t          strb,
  input  logic [VA_W-1:0]      reqVaddr,
  input  logic [RA_W-1:0]      tableBase,
  input  logic [HASH_W-1:0]    tableMask,
  input  logic [ENT_W*ENTS-1:0] memRdData,
  output logic [RA_W-1:0]      memAddr,
  output logic                 entryMatch,
  output logic                 lastStep,
  output logic                 secPass,
  output logic                 done,
  output logic                 fault,
  output logic [RA_W-1:0]      realAddr,
  output logic [$clog2(ENTS)-1:0] hitSlot,
  output logic                 hitSecondary
);
  localparam int STEP_W  = $clog2(ENTS);
  localparam int AVPN_W  = VA_W - PG_W - MINIDX_W;
  localparam int RPN_W   = RA_W - PG_W;
  localparam int PIDX_W  = SEG_W - PG_W;
  localparam int LINE_SH = $clog2(ENT_W / 8 * ENTS);
  localparam int AVPN_LO = 2;
  localparam int RPN_LO  = AVPN_LO + AVPN_W;
  localparam int RSV_LO  = RPN_LO + RPN_W;
  localparam logic [HASH_W-1:0] MIN_MASK = HASH_W'((1 << MINIDX_W) - 1);

  logic [VA_W-1:0]       vaQ;
  logic [RA_W-1:0]       baseQ;
  logic [HASH_W-1:0]     maskQ;
  logic [STEP_W-1:0]     stepQ;
  logic [ENT_W*ENTS-1:0] lineQ;

  // group index
  logic [HASH_W-1:0] primHash, curHash, grpIdx;
  assign primHash = vaQ[SEG_W+HASH_W-1:SEG_W] ^ HASH_W'(vaQ[SEG_W-1:PG_W]);
  assign curHash  = secPass ? ~primHash : primHash;
  assign grpIdx   = curHash & (maskQ | MIN_MASK);
  assign memAddr  = baseQ | (RA_W'(grpIdx) << LINE_SH);

  // slot order: even slots first, then odd
  logic [STEP_W-1:0] slot;
  logic [ENT_W-1:0]  curEnt;
  assign slot   = {stepQ[STEP_W-2:0], stepQ[STEP_W-1]};
  assign curEnt = lineQ[int'(slot)*ENT_W +: ENT_W];

  logic entValid, entHsel, entRsvdZero, entVpnEq;
  assign entValid    = curEnt[0];
  assign entHsel     = curEnt[1];
  assign entRsvdZero = (curEnt[ENT_W-1:RSV_LO] == '0);
  assign entVpnEq    = (curEnt[RPN_LO-1:AVPN_LO] == vaQ[VA_W-1:PG_W+MINIDX_W]);
  assign entryMatch  = entValid && (entHsel == secPass) && entVpnEq && entRsvdZero;
  assign lastStep    = (stepQ == STEP_W'(ENTS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ          <= '0;
      baseQ        <= '0;
      maskQ        <= '0;
      secPass      <= 1'b0;
      stepQ        <= '0;
      lineQ        <= '0;
      done         <= 1'b0;
      fault        <= 1'b0;
      realAddr     <= '0;
      hitSlot      <= '0;
      hitSecondary <= 1'b0;
    end else begin
      done  <= strb.hit;
      fault <= strb.miss;
      if (strb.load) begin
        vaQ     <= reqVaddr;
        baseQ   <= tableBase;
        maskQ   <= tableMask;
        secPass <= 1'b0;
      end
      if (strb.flipPass) secPass <= 1'b1;
      if (strb.capture) begin
        lineQ <= memRdData;
        stepQ <= '0;
      end else if (strb.advance) begin
        stepQ <= stepQ + 1'b1;
      end
      if (strb.hit) begin
        realAddr     <= {curEnt[RSV_LO-1:RPN_LO], vaQ[PG_W-1:0]};
        hitSlot      <= slot;
        hitSecondary <= secPass;
      end
    end
  end

  // R7: a fault is only raised at the end of the second group
  a_r7_fault_after_second: assert property (@(posedge clk) disable iff (!rstN)
    strb.miss |-> (secPass && lastStep));

  // R6: the page offset passes straight through on a hit
  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (realAddr[PG_W-1:0] == vaQ[PG_W-1:0]));

  // R4: the second group is never left for the first again mid-walk
  a_r4_pass_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    (secPass && !strb.load) |=> secPass);
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int VA_W     = 65,
  parameter int RA_W     = 42,
  parameter int HASH_W   = 19,
  parameter int ENT_W    = 128,
  parameter int ENTS     = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [VA_W-1:0]         reqVaddr,
  input  logic [RA_W-1:0]         tableBase,
  input  logic [HASH_W-1:0]       tableMask,
  output logic                    busy,
  output logic                    memReq,
  output logic [RA_W-1:0]         memAddr,
  input  logic                    memRdValid,
  input  logic [ENT_W*ENTS-1:0]   memRdData,
  output logic                    done,
  output logic                    fault,
  output logic [RA_W-1:0]         realAddr,
  output logic [$clog2(ENTS)-1:0] hitSlot,
  output logic                    hitSecondary
);
  walkStrobe_t strb;
  logic entryMatch, lastStep, secPass;

  hpt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRdValid (memRdValid),
    .entryMatch (entryMatch),
    .lastStep   (lastStep),
    .secPass    (secPass),
    .strb       (strb),
    .memReq     (memReq),
    .busy       (busy)
  );

  hpt_dpath #(
    .VA_W   (VA_W),
    .RA_W   (RA_W),
    .HASH_W (HASH_W),
    .ENT_W  (ENT_W),
    .ENTS   (ENTS)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqVaddr     (reqVaddr),
    .tableBase    (tableBase),
    .tableMask    (tableMask),
    .memRdData    (memRdData),
    .memAddr      (memAddr),
    .entryMatch   (entryMatch),
    .lastStep     (lastStep),
    .secPass      (secPass),
    .done         (done),
    .fault        (fault),
    .realAddr     (realAddr),
    .hitSlot      (hitSlot),
    .hitSecondary (hitSecondary)
  );

  // R8: completion pulses are exclusive
  a_r8_done_fault_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fault));

  // R8: busy drops exactly when the completion pulse appears
  a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rstN)
    (done || fault) |-> (!busy && $past(busy)));
endmodule

// File: tb/hpt_walker_bench.sv
module hpt_walker_bench;
  localparam logic [41:0] BASE = 42'h3C0_0000_0000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [64:0]   reqVaddr = '0;
  logic [41:0]   tableBase = BASE;
  logic [18:0]   tableMask = '0;
  logic          busy, memReq, memRdValid, done, fault, hitSecondary;
  logic [41:0]   memAddr, realAddr;
  logic [1023:0] memRdData;
  logic [2:0]    hitSlot;

  always #2 clk = ~clk;

  hpt_walker u_hpt_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .tableBase(tableBase), .tableMask(tableMask), .busy(busy),
    .memReq(memReq), .memAddr(memAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .done(done), .fault(fault),
    .realAddr(realAddr), .hitSlot(hitSlot), .hitSecondary(hitSecondary)
  );

  int nChecks = 0;
  int nFails = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: two lines, 2-cycle latency
  logic [1023:0] priLine = '0, secLine = '0;
  logic [41:0]   priAddr = '0, secAddr = '0;
  logic [41:0]   pendAddr = '0;
  logic [1:0]    lat = '0;
  logic          logClr = 1'b0;
  int            fetchCnt = 0;
  logic [41:0]   fetchLog [4];

  initial begin
    memRdValid = 1'b0;
    memRdData  = '0;
  end

  always @(posedge clk) begin
    memRdValid <= 1'b0;
    if (memReq) begin
      pendAddr <= memAddr;
      lat <= 2'd2;
    end else if (lat != 0) begin
      lat <= lat - 1'b1;
      if (lat == 2'd1) begin
        memRdValid <= 1'b1;
        memRdData  <= (pendAddr == priAddr) ? priLine :
                      (pendAddr == secAddr) ? secLine : '0;
      end
    end
    if (logClr) fetchCnt <= 0;
    else if (memReq) begin
      if (fetchCnt < 4) fetchLog[fetchCnt] <= memAddr;
      fetchCnt <= fetchCnt + 1;
    end
  end

  function automatic logic [41:0] grpAddr(input logic [36:0] vsid, input logic [15:0] pidx,
                                          input logic [18:0] mask, input bit sec);
    logic [18:0] h;
    h = vsid[18:0] ^ {3'b000, pidx};
    if (sec) h = ~h;
    h = h & (mask | 19'h007FF);
    return BASE | ({23'b0, h} << 7);
  endfunction

  function automatic logic [127:0] mkEnt(input bit v, input bit hs, input logic [41:0] avpn,
                                         input logic [29:0] rpn);
    return {54'b0, rpn, avpn, hs, v};
  endfunction

  function automatic logic [1023:0] putEnt(input logic [1023:0] line, input int slot,
                                           input logic [127:0] e);
    logic [1023:0] l;
    l = line;
    l[slot*128 +: 128] = e;
    return l;
  endfunction

  // results of the last walk
  bit          gDone, gFault, gSec;
  logic [41:0] gAddr;
  logic [2:0]  gSlot;

  task automatic setup(input logic [36:0] vsid, input logic [15:0] pidx, input logic [18:0] mask);
    priAddr   = grpAddr(vsid, pidx, mask, 1'b0);
    secAddr   = grpAddr(vsid, pidx, mask, 1'b1);
    priLine   = '0;
    secLine   = '0;
    tableMask = mask;
  endtask

  task automatic runReq(input logic [64:0] va, input bit intrude);
    int t;
    @(negedge clk);
    logClr   = 1'b1;
    reqVaddr = va;
    reqValid = 1'b1;
    @(negedge clk);
    logClr   = 1'b0;
    reqValid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
    if (intrude) begin
      reqVaddr = ~va;
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      reqVaddr = '0;
    end
    t = 0;
    while (!(done || fault) && t < 200) begin
      @(negedge clk);
      t++;
    end
    if (t >= 200) chk(1'b0, "R8 walk timeout", 64'(t), 64'd0);
    gDone  = done;
    gFault = fault;
    gAddr  = realAddr;
    gSlot  = hitSlot;
    gSec   = hitSecondary;
    chk(!busy, "R8 busy low at completion", 64'(busy), 64'd0);
    @(negedge clk);
    chk(!done && !fault, "R6 pulse one cycle", 64'({done, fault}), 64'd0);
  endtask

  typedef struct packed {
    logic [36:0] vsid;
    logic [15:0] pidx;
    logic [11:0] off;
    logic [18:0] mask;
    logic        sec;
    logic [2:0]  slot;
    logic        badH;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{37'h0_1234_5678, 16'hBEEF, 12'h123, 19'h00000, 1'b0, 3'd0, 1'b0},
    '{37'h1_0000_ABCD, 16'h0F0F, 12'hFFF, 19'h7FFFF, 1'b0, 3'd7, 1'b0},
    '{37'h0_FFFF_0001, 16'h8001, 12'h000, 19'h0FFFF, 1'b1, 3'd2, 1'b0},
    '{37'h1_2345_6789, 16'h4242, 12'hA5A, 19'h00F00, 1'b1, 3'd5, 1'b0},
    '{37'h0_0000_0000, 16'h0000, 12'h001, 19'h00000, 1'b1, 3'd0, 1'b0},
    '{37'h0_5555_AAAA, 16'h1357, 12'h777, 19'h3FFFF, 1'b0, 3'd3, 1'b1}
  };

  initial begin
    #400000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [41:0] avpn;
    logic [29:0] rpn;
    logic [64:0] va;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !fault && !memReq, "R10 reset outputs",
        64'({busy, done, fault, memReq}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memReq, "R10 idle after reset", 64'({busy, memReq}), 64'd0);

    // vector table
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      v    = VECS[i];
      avpn = {v.vsid, v.pidx[15:11]};
      rpn  = {v.vsid[13:0], v.pidx};
      va   = {v.vsid, v.pidx, v.off};
      setup(v.vsid, v.pidx, v.mask);
      if (v.sec)
        secLine = putEnt(secLine, int'(v.slot), mkEnt(1'b1, v.badH ? 1'b0 : 1'b1, avpn, rpn));
      else
        priLine = putEnt(priLine, int'(v.slot), mkEnt(1'b1, v.badH ? 1'b1 : 1'b0, avpn, rpn));
      runReq(va, 1'b0);
      chk(fetchLog[0] == priAddr, "R1 first group address", 64'(fetchLog[0]), 64'(priAddr));
      if (v.badH) begin
        chk(gFault && !gDone, "R5/R7 wrong flag gives fault", 64'({gFault, gDone}), 64'b10);
        chk(fetchCnt == 2, "R7 two reads before fault", 64'(fetchCnt), 64'd2);
      end else begin
        chk(gDone && !gFault, "R6 done on match", 64'({gDone, gFault}), 64'b10);
        chk(gAddr == {rpn, v.off}, "R6 real address", 64'(gAddr), 64'({rpn, v.off}));
        chk(gSlot == v.slot, "R6 hit slot", 64'(gSlot), 64'(v.slot));
        chk(gSec == v.sec, "R6 hit group", 64'(gSec), 64'(v.sec));
        chk(fetchCnt == (v.sec ? 2 : 1), "R4 read count", 64'(fetchCnt), 64'(v.sec ? 2 : 1));
        if (v.sec)
          chk(fetchLog[1] == secAddr, "R2 second group address", 64'(fetchLog[1]), 64'(secAddr));
      end
    end

    // R3: odd slot 1 and even slot 2 both match -> slot 2
    avpn = {37'h0_0ABC_DEF0, 5'h03};
    va   = {37'h0_0ABC_DEF0, 16'h1800, 12'h045};
    setup(37'h0_0ABC_DEF0, 16'h1800, 19'h00000);
    priLine = putEnt(priLine, 1, mkEnt(1'b1, 1'b0, avpn, 30'h1111));
    priLine = putEnt(priLine, 2, mkEnt(1'b1, 1'b0, avpn, 30'h2222));
    runReq(va, 1'b0);
    chk(gSlot == 3'd2, "R3 even slot before odd", 64'(gSlot), 64'd2);

    // R3: slot 6 beats slot 1
    priLine = '0;
    priLine = putEnt(priLine, 1, mkEnt(1'b1, 1'b0, avpn, 30'h1111));
    priLine = putEnt(priLine, 6, mkEnt(1'b1, 1'b0, avpn, 30'h6666));
    runReq(va, 1'b0);
    chk(gSlot == 3'd6 && gAddr == {30'h6666, 12'h045}, "R3 slot 6 before slot 1",
        64'(gSlot), 64'd6);

    // R4: first group slot 7 beats second group slot 0
    priLine = '0;
    priLine = putEnt(priLine, 7, mkEnt(1'b1, 1'b0, avpn, 30'h7777));
    secLine = putEnt(secLine, 0, mkEnt(1'b1, 1'b1, avpn, 30'h0101));
    runReq(va, 1'b0);
    chk(!gSec && gSlot == 3'd7 && fetchCnt == 1, "R4 first group wins",
        64'({gSec, gSlot}), 64'h7);

    // R5: invalid, wrong page number, reserved bit set all skipped
    setup(37'h0_0ABC_DEF0, 16'h1800, 19'h00000);
    priLine = putEnt(priLine, 0, mkEnt(1'b0, 1'b0, avpn, 30'h0BAD));
    priLine = putEnt(priLine, 2, mkEnt(1'b1, 1'b0, avpn ^ 42'h1, 30'h0BAD));
    priLine = putEnt(priLine, 4, mkEnt(1'b1, 1'b0, avpn, 30'h0BAD) | {1'b1, 127'b0});
    secLine = putEnt(secLine, 3, mkEnt(1'b1, 1'b1, avpn, 30'h3333));
    runReq(va, 1'b0);
    chk(gDone && gSec && gSlot == 3'd3, "R5 non-matching entries skipped",
        64'({gSec, gSlot}), 64'hB);

    // R7: empty table faults after two reads
    setup(37'h0_0ABC_DEF0, 16'h1800, 19'h00000);
    runReq(va, 1'b0);
    chk(gFault && !gDone && fetchCnt == 2, "R7 empty table fault",
        64'({gFault, fetchCnt[3:0]}), 64'h12);

    // R9: request while busy is ignored
    setup(37'h0_0ABC_DEF0, 16'h1800, 19'h00000);
    secLine = putEnt(secLine, 5, mkEnt(1'b1, 1'b1, avpn, 30'h5555));
    runReq(va, 1'b1);
    chk(gDone && gAddr == {30'h5555, 12'h045}, "R9 intruding request ignored",
        64'(gAddr), 64'({30'h5555, 12'h045}));
    chk(fetchCnt == 2 && fetchLog[0] == priAddr && fetchLog[1] == secAddr,
        "R9 read sequence unchanged", 64'(fetchCnt), 64'd2);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule